// File: doc/BRIEF.md
# PC Card I/O Bus Controller

This block is a bus master that turns single host requests into I/O read and write cycles on a PC Card style I/O bus. The host presents a space index, a direction, a byte/word size, an address and write data for one clock. The controller then drives the active-low card enables, the address, the data lines and the I/O read or write strobe for that space. It ends every access with a one-clock done pulse, and read data is valid while that pulse is high.

Each space has its own configuration: I/O-card versus memory-card mode (the controller only acts in I/O mode), an 8- or 16-bit bus, little- or big-endian byte order, and a setup delay counted in clocks between enable assertion and strobe assertion. In a 16-bit little-endian space, a word access checks the card's 16-bit-capable input at the first card-cycle state. If the card reports an 8-bit port there, the controller narrows that access on the fly into two byte cycles and merges the read bytes. In big-endian mode that input is ignored.

Top module: `pcio_bus_ctrl`

## Requirements
- R1: A request to a space whose mode bit `cfg_io_mode` is 0 (memory-card mode) is ignored: no card enable moves and no done pulse follows.
- R2: Each card cycle starts with an address state in which the card enables are asserted. The strobe falls 1 + `dly` clocks after that state begins, where `dly` is the space's setup field. It stays low for `STRB_CYC` clocks, and it rises one clock before the card enables go inactive. The address is stable while the strobe is low.
- R3: A word access in a 16-bit space with the 16-bit-capable input low runs one card cycle with both enables low, address bit 0 forced to 0, and all 16 data bits.
- R4: A little-endian word access in a 16-bit space with the 16-bit-capable input high at the address state runs two 8-bit cycles, each with only the low enable asserted and data on bits 7:0. The first uses the even address and the second the odd address.
- R5: For a word access in a 16-bit space the high enable is asserted in the address state. From the next clock it reflects the sampled input, asserted only if the access was not split.
- R6: In big-endian mode the 16-bit-capable input is ignored and word accesses in 16-bit spaces always run one full cycle. The byte at the even card address is the high byte of the host word (bits 15:8); in little-endian mode it is the low byte.
- R7: A byte access runs one cycle with only the low enable, the address unchanged, the byte on data bits 7:0, and the 16-bit-capable input not consulted. A byte read returns zero in bits 15:8.
- R8: A word access to an 8-bit space always runs two byte cycles, even address then odd, whatever the 16-bit-capable input is.
- R9: Read data returned with done merges the bytes according to the endianness of the space, for full and split accesses alike.
- R10: Done is high for exactly one clock, in the clock after the last card cycle, when all enables are already inactive. With n card cycles it comes n·(3 + `dly` + `STRB_CYC` − 1) clocks after the first address state.
- R11: A request presented while an access is in progress is ignored.
- R12: Only the selected space's enables ever assert; at most one space is active at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | One-clock request strobe, taken only when idle |
| req_space | input | SW | Space index |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | AW | Card I/O address |
| req_wdata | input | 16 | Host write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| cfg_io_mode | input | NSPACE | Per space: 1 = I/O card, 0 = memory card |
| cfg_bus16 | input | NSPACE | Per space: 1 = 16-bit bus |
| cfg_big_end | input | NSPACE | Per space: 1 = big-endian |
| cfg_setup_dly | input | NSPACE·DLYW | Per space setup delay in clocks |
| card_ce1_n | output | NSPACE | Low-byte card enable per space, active low |
| card_ce2_n | output | NSPACE | High-byte card enable per space, active low |
| card_iord_n | output | 1 | I/O read strobe, active low |
| card_iowr_n | output | 1 | I/O write strobe, active low |
| card_addr | output | AW | Card address |
| card_d_out | output | 16 | Card write data |
| card_d_oe | output | 1 | Card data drive enable |
| card_d_in | input | 16 | Card read data |
| card_iois16 | input | 1 | Card reports an 8-bit port for this access when high |

## Verification
A wrongly latched split decision shows at the ports in the clock after the address state, as a high enable that stays asserted or drops when it should not. It shows again at the end of the access as one strobe pulse too many or too few and a done pulse out of place. A wrong byte-lane choice stays hidden until it shows up as a corrupted byte in card storage after a write, or as swapped bytes in the read data at done. A wrong setup or strobe counter shifts the first strobe edge and the done pulse by whole clocks, so the bench compares the cycle index of each against the value computed from the configuration.

// File: rtl/pcio_pkg.sv
package pcio_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_SETUP,
        PH_STRB,
        PH_HOLD,
        PH_DONE
    } phase_e;

    // How a request maps onto card cycles before the card is asked.
    typedef enum logic [1:0] {
        K_BYTE,   // one 8-bit cycle
        K_FULL,   // one 16-bit cycle, no probing
        K_PROBE,  // 16-bit unless the card reports an 8-bit port
        K_PAIR    // always two 8-bit cycles
    } kind_e;

    typedef struct packed {
        logic        wr;
        logic        word;
        logic        big;
        logic [15:0] wdata;
    } hreq_t;

    function automatic kind_e classify(input logic word, input logic bus16, input logic big);
        if (!word)      return K_BYTE;
        else if (!bus16) return K_PAIR;
        else if (big)   return K_FULL;
        else            return K_PROBE;
    endfunction

    function automatic logic [7:0] even_byte(input logic [15:0] w, input logic big);
        return big ? w[15:8] : w[7:0];
    endfunction

    function automatic logic [7:0] odd_byte(input logic [15:0] w, input logic big);
        return big ? w[7:0] : w[15:8];
    endfunction

    function automatic logic [15:0] lane_swap(input logic [15:0] w, input logic big);
        return big ? {w[7:0], w[15:8]} : w;
    endfunction

endpackage

// File: rtl/pcio_kind_dec.sv
module pcio_kind_dec
    import pcio_pkg::*;
#(
    parameter int NSPACE = 2,
    parameter int SW     = 1,
    parameter int DLYW   = 3
) (
    input  logic                   req,
    input  logic [SW-1:0]          req_space,
    input  logic                   req_word,
    input  logic [NSPACE-1:0]      cfg_io_mode,
    input  logic [NSPACE-1:0]      cfg_bus16,
    input  logic [NSPACE-1:0]      cfg_big_end,
    input  logic [NSPACE*DLYW-1:0] cfg_setup_dly,
    output logic                   start,
    output kind_e                  kind,
    output logic                   big,
    output logic [DLYW-1:0]        dly
);

    always_comb begin
        start = 1'b0;
        kind  = K_BYTE;
        big   = 1'b0;
        dly   = '0;
        for (int s = 0; s < NSPACE; s++) begin
            if (SW'(s) == req_space) begin
                start = req && cfg_io_mode[s];
                kind  = classify(req_word, cfg_bus16[s], cfg_big_end[s]);
                big   = cfg_big_end[s];
                dly   = cfg_setup_dly[s*DLYW +: DLYW];
            end
        end
    end

endmodule

// File: rtl/pcio_seq.sv
module pcio_seq
    import pcio_pkg::*;
#(
    parameter int DLYW     = 3,
    parameter int STRB_CYC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  kind_e           kind,
    input  logic [DLYW-1:0] dly,
    input  logic            iois16,
    output phase_e          phase,
    output logic            second,
    output logic            wide,
    output logic            accept,
    output logic            capture
);

    localparam int SCW = $clog2(STRB_CYC + 1);
    localparam int CW  = ((DLYW > SCW) ? DLYW : SCW) + 1;

    logic [CW-1:0]   cnt;
    logic [DLYW-1:0] dly_q;
    logic            pair;
    logic            probe;
    logic            last_strb;
    logic            last_setup;

    assign last_strb  = (cnt + 1'b1) == CW'(STRB_CYC);
    assign last_setup = (cnt + 1'b1) == CW'(dly_q);
    assign accept     = (phase == PH_IDLE) && start;
    assign capture    = (phase == PH_STRB) && last_strb;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            dly_q  <= '0;
            second <= 1'b0;
            pair   <= 1'b0;
            probe  <= 1'b0;
            wide   <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase  <= PH_ADDR;
                    cnt    <= '0;
                    dly_q  <= dly;
                    second <= 1'b0;
                    pair   <= (kind == K_PAIR);
                    probe  <= (kind == K_PROBE);
                    wide   <= (kind == K_FULL) || (kind == K_PROBE);
                end
                PH_ADDR: begin
                    // one sample decides the bus size for the whole access
                    if (probe) begin
                        pair  <= iois16;
                        wide  <= !iois16;
                        probe <= 1'b0;
                    end
                    cnt   <= '0;
                    phase <= (dly_q == '0) ? PH_STRB : PH_SETUP;
                end
                PH_SETUP: begin
                    if (last_setup) begin
                        cnt   <= '0;
                        phase <= PH_STRB;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_STRB: begin
                    if (last_strb) begin
                        cnt   <= '0;
                        phase <= PH_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (pair && !second) begin
                        second <= 1'b1;
                        phase  <= PH_ADDR;
                    end else begin
                        phase <= PH_DONE;
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pcio_lane.sv
module pcio_lane
    import pcio_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  hreq_t         hreq,
    input  logic [AW-1:0] haddr,
    input  phase_e        phase,
    input  logic          second,
    input  logic          wide,
    input  logic          capture,
    input  logic [15:0]   card_d_in,
    output logic          wr_q,
    output logic [AW-1:0] card_addr,
    output logic [15:0]   card_d_out,
    output logic          card_d_oe,
    output logic [15:0]   rdata
);

    hreq_t         rq;
    logic [AW-1:0] addr_q;
    logic          in_cycle;

    assign wr_q     = rq.wr;
    assign in_cycle = (phase == PH_ADDR) || (phase == PH_SETUP) ||
                      (phase == PH_STRB) || (phase == PH_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            rq     <= '0;
            addr_q <= '0;
            rdata  <= '0;
        end else begin
            if (accept) begin
                rq     <= hreq;
                addr_q <= haddr;
            end
            if (capture) begin
                if (wide)
                    rdata <= lane_swap(card_d_in, rq.big);
                else if (!rq.word)
                    rdata <= {8'h00, card_d_in[7:0]};
                else if (second ^ rq.big)
                    rdata[15:8] <= card_d_in[7:0];
                else
                    rdata[7:0] <= card_d_in[7:0];
            end
        end
    end

    always_comb begin
        card_addr = rq.word ? {addr_q[AW-1:1], second} : addr_q;
        if (wide)
            card_d_out = lane_swap(rq.wdata, rq.big);
        else if (!rq.word)
            card_d_out = {8'h00, rq.wdata[7:0]};
        else if (second)
            card_d_out = {8'h00, odd_byte(rq.wdata, rq.big)};
        else
            card_d_out = {8'h00, even_byte(rq.wdata, rq.big)};
        card_d_oe = rq.wr && in_cycle;
    end

endmodule

// File: rtl/pcio_bus_ctrl.sv
module pcio_bus_ctrl
    import pcio_pkg::*;
#(
    parameter int NSPACE   = 2,
    parameter int AW       = 8,
    parameter int DLYW     = 3,
    parameter int STRB_CYC = 2,
    localparam int SW      = (NSPACE > 1) ? $clog2(NSPACE) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic [SW-1:0]          req_space,
    input  logic                   req_wr,
    input  logic                   req_word,
    input  logic [AW-1:0]          req_addr,
    input  logic [15:0]            req_wdata,
    output logic                   rsp_done,
    output logic [15:0]            rsp_rdata,
    input  logic [NSPACE-1:0]      cfg_io_mode,
    input  logic [NSPACE-1:0]      cfg_bus16,
    input  logic [NSPACE-1:0]      cfg_big_end,
    input  logic [NSPACE*DLYW-1:0] cfg_setup_dly,
    output logic [NSPACE-1:0]      card_ce1_n,
    output logic [NSPACE-1:0]      card_ce2_n,
    output logic                   card_iord_n,
    output logic                   card_iowr_n,
    output logic [AW-1:0]          card_addr,
    output logic [15:0]            card_d_out,
    output logic                   card_d_oe,
    input  logic [15:0]            card_d_in,
    input  logic                   card_iois16
);

    logic            start;
    kind_e           kind;
    logic            big;
    logic [DLYW-1:0] dly;
    phase_e          phase;
    logic            second;
    logic            wide;
    logic            accept;
    logic            capture;
    logic            wr_q;
    logic [SW-1:0]   sp_q;
    logic            active;
    hreq_t           hreq;

    assign hreq = '{wr: req_wr, word: req_word, big: big, wdata: req_wdata};

    pcio_kind_dec #(.NSPACE(NSPACE), .SW(SW), .DLYW(DLYW)) u_dec (
        .req          (req),
        .req_space    (req_space),
        .req_word     (req_word),
        .cfg_io_mode  (cfg_io_mode),
        .cfg_bus16    (cfg_bus16),
        .cfg_big_end  (cfg_big_end),
        .cfg_setup_dly(cfg_setup_dly),
        .start        (start),
        .kind         (kind),
        .big          (big),
        .dly          (dly)
    );

    pcio_seq #(.DLYW(DLYW), .STRB_CYC(STRB_CYC)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .kind   (kind),
        .dly    (dly),
        .iois16 (card_iois16),
        .phase  (phase),
        .second (second),
        .wide   (wide),
        .accept (accept),
        .capture(capture)
    );

    pcio_lane #(.AW(AW)) u_lane (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .hreq      (hreq),
        .haddr     (req_addr),
        .phase     (phase),
        .second    (second),
        .wide      (wide),
        .capture   (capture),
        .card_d_in (card_d_in),
        .wr_q      (wr_q),
        .card_addr (card_addr),
        .card_d_out(card_d_out),
        .card_d_oe (card_d_oe),
        .rdata     (rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)         sp_q <= '0;
        else if (accept) sp_q <= req_space;
    end

    assign active      = (phase == PH_ADDR) || (phase == PH_SETUP) ||
                         (phase == PH_STRB) || (phase == PH_HOLD);
    assign card_iord_n = !((phase == PH_STRB) && !wr_q);
    assign card_iowr_n = !((phase == PH_STRB) && wr_q);
    assign rsp_done    = (phase == PH_DONE);

    for (genvar s = 0; s < NSPACE; s++) begin : g_ce
        assign card_ce1_n[s] = !(active && (sp_q == SW'(s)));
        assign card_ce2_n[s] = !(active && wide && (sp_q == SW'(s)));
    end

endmodule

// File: rtl/pcio_bus_ctrl_chk.sv
module pcio_bus_ctrl_chk #(
    parameter int NSPACE = 2,
    parameter int AW     = 8,
    parameter int SW     = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              req,
    input logic [SW-1:0]     req_space,
    input logic [NSPACE-1:0] cfg_io_mode,
    input logic              rsp_done,
    input logic [NSPACE-1:0] card_ce1_n,
    input logic [NSPACE-1:0] card_ce2_n,
    input logic              card_iord_n,
    input logic              card_iowr_n,
    input logic [AW-1:0]     card_addr,
    input logic              card_d_oe
);

    logic strobe;
    logic all_off;
    assign strobe  = !card_iord_n || !card_iowr_n;
    assign all_off = (&card_ce1_n) && (&card_ce2_n);

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    a_r10_done_enables_off: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> all_off);

    a_r2_strobe_inside_enable: assert property (@(posedge clk) disable iff (rst)
        strobe |-> !(&card_ce1_n));

    a_r2_strobe_rises_first: assert property (@(posedge clk) disable iff (rst)
        ($rose(card_iord_n) || $rose(card_iowr_n)) |-> !(&card_ce1_n));

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (strobe && $past(strobe)) |-> $stable(card_addr));

    a_r12_one_space: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~card_ce1_n));

    a_r3_high_needs_low: assert property (@(posedge clk) disable iff (rst)
        ((~card_ce2_n) & card_ce1_n) == '0);

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!card_iord_n && !card_iowr_n));

    a_r2_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        card_d_oe |-> card_iord_n);

    // R1: an idle request to a memory-mode space leaves every enable off
    a_r1_memory_mode_idle: assert property (@(posedge clk) disable iff (rst)
        (req && (cfg_io_mode[req_space] == 1'b0) && all_off && !rsp_done) |=> all_off);

endmodule

bind pcio_bus_ctrl pcio_bus_ctrl_chk #(.NSPACE(NSPACE), .AW(AW), .SW(SW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .req_space  (req_space),
    .cfg_io_mode(cfg_io_mode),
    .rsp_done   (rsp_done),
    .card_ce1_n (card_ce1_n),
    .card_ce2_n (card_ce2_n),
    .card_iord_n(card_iord_n),
    .card_iowr_n(card_iowr_n),
    .card_addr  (card_addr),
    .card_d_oe  (card_d_oe)
);

// File: tb/pcio_bus_ctrl_test.sv
module pcio_bus_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSPACE     = 2;
    localparam int AW         = 8;
    localparam int DLYW       = 3;
    localparam int STRB_CYC   = 2;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   req;
    logic [0:0]             req_space;
    logic                   req_wr;
    logic                   req_word;
    logic [AW-1:0]          req_addr;
    logic [15:0]            req_wdata;
    logic                   rsp_done;
    logic [15:0]            rsp_rdata;
    logic [NSPACE-1:0]      cfg_io_mode;
    logic [NSPACE-1:0]      cfg_bus16;
    logic [NSPACE-1:0]      cfg_big_end;
    logic [NSPACE*DLYW-1:0] cfg_setup_dly;
    logic [NSPACE-1:0]      card_ce1_n;
    logic [NSPACE-1:0]      card_ce2_n;
    logic                   card_iord_n;
    logic                   card_iowr_n;
    logic [AW-1:0]          card_addr;
    logic [15:0]            card_d_out;
    logic                   card_d_oe;
    logic [15:0]            card_d_in;
    logic                   card_iois16;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] mem [NSPACE][256];

    always #(CLK_PERIOD/2) clk = ~clk;

    pcio_bus_ctrl #(.NSPACE(NSPACE), .AW(AW), .DLYW(DLYW), .STRB_CYC(STRB_CYC)) uut (
        .clk(clk), .rst(rst), .req(req), .req_space(req_space), .req_wr(req_wr),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .cfg_io_mode(cfg_io_mode),
        .cfg_bus16(cfg_bus16), .cfg_big_end(cfg_big_end), .cfg_setup_dly(cfg_setup_dly),
        .card_ce1_n(card_ce1_n), .card_ce2_n(card_ce2_n), .card_iord_n(card_iord_n),
        .card_iowr_n(card_iowr_n), .card_addr(card_addr), .card_d_out(card_d_out),
        .card_d_oe(card_d_oe), .card_d_in(card_d_in), .card_iois16(card_iois16)
    );

    // Card model: 8-bit port when only the low enable is asserted
    always_comb begin
        card_d_in = 16'h0000;
        for (int s = 0; s < NSPACE; s++) begin
            if (!card_ce1_n[s]) begin
                if (!card_ce2_n[s])
                    card_d_in = {mem[s][{card_addr[7:1], 1'b1}], mem[s][{card_addr[7:1], 1'b0}]};
                else
                    card_d_in = {8'h00, mem[s][card_addr]};
            end
        end
    end

    always @(negedge clk) begin
        for (int s = 0; s < NSPACE; s++) begin
            if (!card_ce1_n[s] && !card_iowr_n) begin
                if (!card_ce2_n[s]) begin
                    mem[s][{card_addr[7:1], 1'b0}] = card_d_out[7:0];
                    mem[s][{card_addr[7:1], 1'b1}] = card_d_out[15:8];
                end else begin
                    mem[s][card_addr] = card_d_out[7:0];
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int halves(input bit word, input bit b16, input bit big, input bit iois);
        if (!word) return 1;
        if (!b16)  return 2;
        if (big)   return 1;
        return iois ? 2 : 1;
    endfunction

    function automatic string kind_tag(input bit word, input bit b16, input bit big, input bit iois);
        if (!word) return "R7";
        if (!b16)  return "R8";
        if (big)   return "R6";
        return iois ? "R4" : "R3";
    endfunction

    task automatic set_cfg(input int sp, input bit io, input bit b16, input bit big, input int dly);
        cfg_io_mode[sp] = io;
        cfg_bus16[sp]   = b16;
        cfg_big_end[sp] = big;
        cfg_setup_dly[sp*DLYW +: DLYW] = DLYW'(dly);
    endtask

    task automatic do_access(input int sp, input bit wr, input bit word,
                             input logic [7:0] a, input logic [15:0] wd,
                             input bit iois, input bit poke);
        bit    io   = cfg_io_mode[sp];
        bit    b16  = cfg_bus16[sp];
        bit    big  = cfg_big_end[sp];
        int    dly  = int'(cfg_setup_dly[sp*DLYW +: DLYW]);
        int    n    = halves(word, b16, big, iois);
        int    len  = 3 + dly + STRB_CYC - 1;
        int    done_exp = n * len;
        string tg   = kind_tag(word, b16, big, iois);
        logic [7:0] a0 = {a[7:1], 1'b0};
        logic [15:0] exp_rd;
        int    strobes = 0, first_str = -1, done_at = -1, done_cnt = 0;
        bit    prev_str = 0, other_bad = 0;
        logic [7:0] saddr [2];
        logic [15:0] rd_at_done = 16'h0;

        if (!word)    exp_rd = {8'h00, mem[sp][a]};
        else if (big) exp_rd = {mem[sp][a0], mem[sp][a0 | 8'h01]};
        else          exp_rd = {mem[sp][a0 | 8'h01], mem[sp][a0]};

        req = 1'b1; req_space = 1'(sp); req_wr = wr; req_word = word;
        req_addr = a; req_wdata = wd; card_iois16 = iois;
        @(negedge clk);
        req = 1'b0;

        if (!io) begin
            for (int i = 0; i < 30; i++) begin
                if (!(&card_ce1_n) || rsp_done) other_bad = 1;
                @(negedge clk);
            end
            check(!other_bad, "R1", "memory-mode space produced activity", other_bad, 0);
            return;
        end

        for (int idx = 0; idx < done_exp + 3; idx++) begin
            bit s = wr ? !card_iowr_n : !card_iord_n;
            if (idx == 0) begin
                check(card_ce1_n[sp] == 1'b0, "R2", "low enable in address state", card_ce1_n[sp], 0);
                check(card_ce2_n[sp] == !(word && b16), "R5", "high enable in address state",
                      card_ce2_n[sp], !(word && b16));
            end
            if (idx == 1)
                check(card_ce2_n[sp] == !(word && b16 && n == 1), "R5", "high enable after sampling",
                      card_ce2_n[sp], !(word && b16 && n == 1));
            if (s && !prev_str) begin
                if (first_str < 0) first_str = idx;
                if (strobes < 2) saddr[strobes] = card_addr;
                strobes++;
            end
            prev_str = s;
            if (rsp_done) begin
                done_cnt++;
                if (done_at < 0) begin done_at = idx; rd_at_done = rsp_rdata; end
            end
            for (int o = 0; o < NSPACE; o++)
                if (o != sp && (!card_ce1_n[o] || !card_ce2_n[o])) other_bad = 1;
            if (poke && idx == 2) begin
                req = 1'b1; req_wr = !wr; req_word = 1'b0; req_addr = a ^ 8'h55;
            end
            if (poke && idx == 3) req = 1'b0;
            @(negedge clk);
        end

        check(first_str == 1 + dly, "R2", "first strobe clock index", first_str, 1 + dly);
        check(strobes == n, tg, "number of card cycles", strobes, n);
        check(done_at == done_exp, "R10", "done clock index", done_at, done_exp);
        check(done_cnt == 1, "R10", "done pulse width", done_cnt, 1);
        check(!other_bad, "R12", "unselected space enable moved", other_bad, 0);
        if (n == 1)
            check(saddr[0] == (word ? a0 : a), tg, "card address", saddr[0], word ? a0 : a);
        else if (strobes == 2) begin
            check(saddr[0] == a0, tg, "first byte cycle address", saddr[0], a0);
            check(saddr[1] == (a0 | 8'h01), tg, "second byte cycle address", saddr[1], a0 | 8'h01);
        end
        if (wr) begin
            if (!word)
                check(mem[sp][a] == wd[7:0], "R7", "byte written", mem[sp][a], wd[7:0]);
            else begin
                check(mem[sp][a0] == (big ? wd[15:8] : wd[7:0]), big ? "R6" : tg,
                      "even byte written", mem[sp][a0], big ? wd[15:8] : wd[7:0]);
                check(mem[sp][a0 | 8'h01] == (big ? wd[7:0] : wd[15:8]), big ? "R6" : tg,
                      "odd byte written", mem[sp][a0 | 8'h01], big ? wd[7:0] : wd[15:8]);
            end
        end else begin
            check(rd_at_done == exp_rd, "R9", "read data at done", rd_at_done, exp_rd);
        end
        if (poke) begin
            bit quiet = 1;
            for (int i = 0; i < 6; i++) begin
                if (!(&card_ce1_n) || rsp_done) quiet = 0;
                @(negedge clk);
            end
            check(quiet, "R11", "request during busy access was taken", !quiet, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C0D));
        for (int s = 0; s < NSPACE; s++)
            for (int i = 0; i < 256; i++) mem[s][i] = 8'($urandom);
        rst = 1'b1; req = 1'b0; req_space = '0; req_wr = 0; req_word = 0;
        req_addr = '0; req_wdata = '0; card_iois16 = 0;
        cfg_io_mode = '1; cfg_bus16 = '1; cfg_big_end = '0; cfg_setup_dly = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        check(&card_ce1_n && &card_ce2_n, "R12", "enables after reset", {card_ce1_n, card_ce2_n}, 4'hF);
        check(card_iord_n && card_iowr_n, "R2", "strobes after reset", {card_iord_n, card_iowr_n}, 2'b11);
        check(!rsp_done, "R10", "done after reset", rsp_done, 0);

        // directed corners
        set_cfg(0, 1, 1, 0, 0);
        do_access(0, 1, 1, 8'h10, 16'hA1B2, 0, 0);        // R3 full write
        do_access(0, 0, 1, 8'h11, 16'h0000, 0, 0);        // R3 full read, odd host address
        do_access(0, 1, 1, 8'h20, 16'hC3D4, 1, 0);        // R4 split write
        do_access(0, 0, 1, 8'h20, 16'h0000, 1, 0);        // R4 split read -> R9 merge
        set_cfg(1, 1, 1, 1, 3);
        do_access(1, 1, 1, 8'h30, 16'h1357, 1, 0);        // R6 input ignored
        do_access(1, 0, 1, 8'h30, 16'h0000, 1, 0);        // R6/R9 big-endian read
        do_access(1, 0, 0, 8'h31, 16'h0000, 1, 0);        // R7 byte, input high
        set_cfg(0, 1, 0, 0, 7);
        do_access(0, 1, 1, 8'h40, 16'h9ABC, 0, 0);        // R8 8-bit space, input low
        set_cfg(0, 1, 0, 1, 1);
        do_access(0, 0, 1, 8'h40, 16'h0000, 1, 0);        // R8 big-endian pair read
        set_cfg(1, 0, 1, 0, 2);
        do_access(1, 1, 1, 8'h50, 16'hFFFF, 0, 0);        // R1 memory mode
        set_cfg(1, 1, 1, 0, 2);
        do_access(1, 1, 1, 8'h60, 16'h2468, 1, 1);        // R11 poke while busy

        for (int it = 0; it < 80; it++) begin
            int sp = int'($urandom % NSPACE);
            set_cfg(sp, ($urandom % 6) != 0, 1'($urandom), 1'($urandom), int'($urandom % 8));
            do_access(sp, 1'($urandom), 1'($urandom), 8'($urandom), 16'($urandom),
                      1'($urandom), ($urandom % 10) == 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule